// File: doc/BRIEF.md
# Four-Bin Coincidence Trigger with Shape-Dependent Amplitude Veto

This block turns a set of per-time-bin sub-trigger bits into one final trigger pulse. Each time bin delivers its sub-trigger in its own cycle. Bin 0 arrives first and bin 3 arrives last. A short shift register on each input lines the bins up, so that one event presents all of its bits to a single AND gate in the cycle when the last bin arrives.

An amplitude check runs in parallel with the coincidence. It asks whether the ADC sample, measured above a baseline, reaches a threshold. The check uses the sample taken a fixed number of cycles before the coincidence cycle. That number depends on the pulse-shape mode. When the veto fails, the AND gate is blocked.

Two further rules act on the final trigger. After a trigger fires, it is held off for a short time, so one event cannot be counted twice. When the shape mode changes, the veto history is discarded, and the trigger stays blocked until fresh samples have filled the history again.

Top module: `coinc_trigger`

## Requirements
- R1: Input bit `sub_trig[i]` is delayed by 3−i cycles. A coincidence exists at a clock edge only when, for every i in 0..3, `sub_trig[i]` was high at the edge 3−i edges earlier. A missing or mistimed bin gives no trigger.
- R2: An amplitude sample passes when `adc_amp` ≥ `baseline` and `adc_amp` − `baseline` ≥ `veto_thr`, all three treated as unsigned. Equality with the threshold passes. A sample below the baseline always fails.
- R3: The veto applied at an edge is the pass/fail result of the sample taken D edges earlier. D = 3 when `shape_sel` = 0 (single-bin rising edge) and D = 1 when `shape_sel` = 1 (three-bin rising edge).
- R4: `fire` is a register output. It is high for exactly the one cycle that follows an edge at which the coincidence holds, the delayed veto passes, and no hold-off or flush is in force.
- R5: For the 4 cycles that follow a cycle with `fire` high, `fire` stays low whatever the inputs are.
- R6: At an edge where `shape_sel` differs from its value at the previous edge, no trigger is produced and the veto history is cleared. A trigger can follow again only once D new samples have been taken after that edge.
- R7: While `rst_n` is low at a clock edge, `fire` is cleared, all delay lines are cleared, the remembered mode becomes 0 and the hold-off is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_trig | input | 4 | Sub-trigger bit for each time bin; bit 0 is the earliest bin |
| adc_amp | input | 12 | Current ADC amplitude sample |
| baseline | input | 12 | Baseline subtracted from the sample, held static by the user |
| veto_thr | input | 12 | Minimum amplitude above the baseline |
| shape_sel | input | 1 | Pulse-shape mode: 0 = single-bin edge (veto delay 3), 1 = three-bin edge (veto delay 1) |
| fire | output | 1 | Final trigger, one cycle long |

## Verification
The bench goes after the following corner cases:
- A staircase event whose amplitude sample is placed at the delay of the other mode. A design that taps the wrong stage would trigger on it.
- A sample exactly at the threshold, and one below the baseline with a zero threshold. A comparator with the wrong bound, or with a wrapping subtraction, gets one of these wrong.
- A continuous coincidence. A design with a hold-off that is too short or too long fires with the wrong spacing.
- Rapid mode toggling. A design that keeps the stale veto history, or that gates only the switch edge, fires in the refill window.

// File: rtl/coinc_pkg.sv
// Package: shared types for the coincidence trigger.
// Assumes: shape mode is a single select bit.
package coinc_pkg;

    // Pulse-shape mode; the value sets the veto delay
    typedef enum logic {
        SHAPE_ONE_BIN   = 1'b0,
        SHAPE_THREE_BIN = 1'b1
    } shape_e;

endpackage

// File: rtl/bin_align.sv
// Module: bin_align
// Delays each time-bin input by (N_BINS-1-i) cycles so that all bins of
// one event meet in the cycle when the last bin arrives, then ANDs them.
// Assumes: bin N_BINS-1 is the latest bin and needs no delay.
module bin_align #(
    parameter int N_BINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BINS-1:0] sub_trig,
    output logic              coinc
);

    logic [N_BINS-1:0] aligned;

    for (genvar i = 0; i < N_BINS; i++) begin : g_bin
        localparam int DEPTH = N_BINS - 1 - i;
        if (DEPTH == 0) begin : g_direct
            assign aligned[i] = sub_trig[i];
        end else begin : g_delay
            logic [DEPTH-1:0] line;

            // shift this bin's bit down its own delay line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line <= '0;
                end else begin
                    line[0] <= sub_trig[i];
                    for (int k = 1; k < DEPTH; k++) begin
                        line[k] <= line[k-1];
                    end
                end
            end

            assign aligned[i] = line[DEPTH-1];
        end
    end

    // coincidence of all aligned bins
    always_comb begin
        coinc = &aligned;
    end

endmodule

// File: rtl/veto_path.sv
// Module: veto_path
// Compares the baseline-corrected amplitude with a threshold and delays
// the pass/fail decision by a mode-dependent number of cycles. A change
// of mode clears the history, and the veto then blocks until it refills.
// Assumes: 1 <= DLY_ONE, DLY_THREE; baseline is static between events.
module veto_path
    import coinc_pkg::*;
#(
    parameter int ADC_W     = 12,
    parameter int DLY_ONE   = 3,
    parameter int DLY_THREE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] adc_amp,
    input  logic [ADC_W-1:0] baseline,
    input  logic [ADC_W-1:0] veto_thr,
    input  logic             shape_sel,
    output logic             veto_pass
);

    localparam int MAX_DLY = (DLY_ONE > DLY_THREE) ? DLY_ONE : DLY_THREE;

    logic [ADC_W:0]   diff;
    logic             amp_ok;
    logic             mode_q;
    logic             flush;
    logic             tap;
    logic [MAX_DLY-1:0] hist;

    // baseline subtraction with a borrow bit, then threshold compare
    always_comb begin
        diff   = {1'b0, adc_amp} - {1'b0, baseline};
        amp_ok = !diff[ADC_W] && (diff[ADC_W-1:0] >= veto_thr);
    end

    // remember the mode used at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SHAPE_ONE_BIN;
        end else begin
            mode_q <= shape_sel;
        end
    end

    // a mode change is seen when the select differs from the stored mode
    always_comb begin
        flush = (shape_sel != mode_q);
    end

    // history of pass/fail decisions; cleared on a mode change
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist <= '0;
        end else begin
            hist[0] <= amp_ok;
            for (int k = 1; k < MAX_DLY; k++) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    // pick the stage that matches the current shape mode
    always_comb begin
        if (shape_sel == SHAPE_THREE_BIN) begin
            tap = hist[DLY_THREE-1];
        end else begin
            tap = hist[DLY_ONE-1];
        end
        veto_pass = tap && !flush;
    end

    // R6
    flush_blocks_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !veto_pass);

    // R2
    below_base_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_amp < baseline) |=> !hist[0]);

endmodule

// File: rtl/holdoff_gate.sv
// Module: holdoff_gate
// Registers the final trigger and blocks new triggers for HOLDOFF cycles
// after each one.
// Assumes: coinc and veto_pass are valid in the same cycle.
module holdoff_gate #(
    parameter int HOLDOFF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coinc,
    input  logic veto_pass,
    output logic fire
);

    localparam int CW = $clog2(HOLDOFF + 1);
    localparam int SW = $clog2(HOLDOFF + 2);

    logic [CW-1:0] hold_cnt;
    logic          allow;

    // new triggers allowed only when the hold-off has run out
    always_comb begin
        allow = (hold_cnt == '0);
    end

    // output register and hold-off countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            hold_cnt <= '0;
        end else begin
            fire <= coinc && veto_pass && allow;
            if (coinc && veto_pass && allow) begin
                hold_cnt <= CW'(HOLDOFF);
            end else if (!allow) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

    // checker: cycles elapsed since the last trigger, saturating
    logic [SW-1:0] since_fire;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fire <= SW'(HOLDOFF + 1);
        end else if (fire) begin
            since_fire <= SW'(1);
        end else if (since_fire <= SW'(HOLDOFF)) begin
            since_fire <= since_fire + 1'b1;
        end
    end

    // R5
    holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_fire >= SW'(1) && since_fire <= SW'(HOLDOFF)) |-> !fire);

endmodule

// File: rtl/coinc_trigger.sv
// Module: coinc_trigger (top)
// Aligns per-bin sub-triggers, gates their coincidence with a delayed
// amplitude veto and emits a one-cycle trigger with a hold-off.
// Assumes: bin 0 is the earliest bin; baseline and threshold are quasi-static.
module coinc_trigger #(
    parameter int N_BINS    = 4,
    parameter int ADC_W     = 12,
    parameter int DLY_ONE   = 3,
    parameter int DLY_THREE = 1,
    parameter int HOLDOFF   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BINS-1:0] sub_trig,
    input  logic [ADC_W-1:0]  adc_amp,
    input  logic [ADC_W-1:0]  baseline,
    input  logic [ADC_W-1:0]  veto_thr,
    input  logic              shape_sel,
    output logic              fire
);

    logic coinc;
    logic veto_pass;

    bin_align #(
        .N_BINS (N_BINS)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_trig (sub_trig),
        .coinc    (coinc)
    );

    veto_path #(
        .ADC_W     (ADC_W),
        .DLY_ONE   (DLY_ONE),
        .DLY_THREE (DLY_THREE)
    ) u_veto (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_amp   (adc_amp),
        .baseline  (baseline),
        .veto_thr  (veto_thr),
        .shape_sel (shape_sel),
        .veto_pass (veto_pass)
    );

    holdoff_gate #(
        .HOLDOFF (HOLDOFF)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .coinc     (coinc),
        .veto_pass (veto_pass),
        .fire      (fire)
    );

    // R1
    fire_needs_coinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(coinc));

    // R3
    fire_needs_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(veto_pass));

    // R4
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: tb/sim_coinc_trigger.sv
module sim_coinc_trigger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sub_trig = '0;
    logic [11:0] adc_amp = '0;
    logic [11:0] baseline = 12'd100;
    logic [11:0] veto_thr = 12'd50;
    logic        shape_sel = 1'b0;
    logic        fire;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nfire = 0;

    always #5 clk = ~clk;

    coinc_trigger u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_trig  (sub_trig),
        .adc_amp   (adc_amp),
        .baseline  (baseline),
        .veto_thr  (veto_thr),
        .shape_sel (shape_sel),
        .fire      (fire)
    );

    // behavioural reference model
    logic [3:0] hq[$];
    bit         okq[$];
    bit         mode_m = 0;
    int         hold = 0;
    bit         exp_fire = 0;
    string      tag = "R7";

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = {4'b0, 4'b0, 4'b0};
            okq.delete();
            mode_m = 0;
            hold = 0;
            exp_fire = 0;
            tag = "R7";
        end else begin
            bit co;
            bit ok;
            bit fl;
            bit vt;
            int d;
            co = sub_trig[3];
            for (int i = 0; i < 3; i++) co = co & hq[2-i][i];
            ok = (int'(adc_amp) >= int'(baseline)) &&
                 (int'(adc_amp) - int'(baseline) >= int'(veto_thr));
            fl = (shape_sel != mode_m);
            d = shape_sel ? 1 : 3;
            vt = !fl && (okq.size() >= d) && okq[d-1];
            exp_fire = co && vt && (hold == 0);
            if (exp_fire) tag = "R4";
            else if (hold != 0) tag = "R5";
            else if (fl) tag = "R6";
            else if (!co) tag = "R1";
            else tag = "R2,R3";
            hq.push_front(sub_trig);
            void'(hq.pop_back());
            if (fl) okq.delete();
            else begin
                okq.push_front(ok);
                if (okq.size() > 3) void'(okq.pop_back());
            end
            mode_m = shape_sel;
            if (exp_fire) hold = 4;
            else if (hold > 0) hold--;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        nchk++;
        if (fire) nfire++;
        if (fire !== exp_fire) begin
            nfail++;
            $display("FAIL %s cycle %0d: fire=%0b expected %0b", tag, cyc, fire, exp_fire);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: run did not end");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // one staircase event; amplitude good only in the sample slot 'slot'
    task automatic staircase(int slot, logic [11:0] good, logic [3:0] mask);
        for (int c = 0; c < 4; c++) begin
            sub_trig = mask & (4'b1 << c);
            adc_amp = (c == slot) ? good : 12'd0;
            tick(1);
        end
        sub_trig = '0;
        adc_amp = '0;
        tick(8);
    endtask

    initial begin
        tick(3);
        // R7: fire low after reset is covered by the per-cycle compare
        if (fire !== 1'b0) begin
            nfail++;
            $display("FAIL R7 after reset: fire=%0b expected 0", fire);
        end
        nchk++;
        rst_n = 1'b1;
        tick(2);
        // R1 R3 R4: mode 0, sample three cycles before the last bin
        staircase(0, 12'd200, 4'hF);
        // R3: mode 0 with the sample at the mode-1 slot -> none
        staircase(2, 12'd200, 4'hF);
        // R1: missing bin -> none
        staircase(0, 12'd200, 4'b1101);
        // R6 R3: mode 1, sample one cycle before the last bin
        shape_sel = 1'b1;
        tick(6);
        staircase(2, 12'd200, 4'hF);
        staircase(0, 12'd200, 4'hF);
        // R2: weak amplitude -> none
        staircase(2, 12'd149, 4'hF);
        // R2: exact threshold -> fire
        staircase(2, 12'd150, 4'hF);
        // R2: below baseline with zero threshold -> none; equal baseline -> fire
        veto_thr = 12'd0;
        staircase(2, 12'd90, 4'hF);
        staircase(2, 12'd100, 4'hF);
        veto_thr = 12'd50;
        // R5: continuous coincidence
        sub_trig = 4'hF;
        adc_amp = 12'd300;
        tick(24);
        // R6: toggling mode while coincidence persists
        for (int k = 0; k < 8; k++) begin
            shape_sel = ~shape_sel;
            tick(k % 4 + 1);
        end
        tick(10);
        // random phase covering all rules
        for (int n = 0; n < 8000; n++) begin
            for (int b = 0; b < 4; b++) sub_trig[b] = ($urandom_range(0, 3) != 0);
            adc_amp = 12'($urandom_range(40, 220));
            if ($urandom_range(0, 150) == 0) shape_sel = ~shape_sel;
            if ($urandom_range(0, 500) == 0) veto_thr = 12'($urandom_range(0, 80));
            tick(1);
        end
        sub_trig = '0;
        tick(10);
        // R4: the run must have produced triggers at all
        nchk++;
        if (nfire < 10) begin
            nfail++;
            $display("FAIL R4 trigger count: got %0d expected at least 10", nfire);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule